// File: doc/BRIEF.md
# Scaled Fixed-Point Accumulator Datapath

This block is the arithmetic heart of a fixed-point signal processing core. A 32-bit two's-complement ALU combines the accumulator with a second operand and writes the result back into the accumulator. The second operand is either a 16-bit data word or a full 32-bit product word. The data word first passes through an input scaler, which sign-extends it and shifts it left by 0 to 16 places. The ALU can load, add, subtract, AND, OR or XOR. Signed overflow on add and subtract sets a sticky flag. A mode input chooses whether results wrap or saturate.

A store path returns one 16-bit half of the accumulator. The high half can be taken after a left shift of 0, 1 or 4 places, which rescales it. The low half is always taken unshifted. Operations enter through a valid/ready handshake. Every operation completes in one cycle, so `in_ready` is held high and the block never applies back-pressure. An operation is accepted in each cycle in which `in_valid` is high. The mode, clear and store-select inputs are plain level controls.

Top module: `acc_datapath_core`

## Requirements
- R1: After reset the accumulator reads 0 and the overflow flag is 0. `in_ready` is always 1, so an operation is accepted in every cycle in which `in_valid` is 1.
- R2: When `use_prod`=0, the arithmetic operand is `data_in` sign-extended to 32 bits and shifted left by `shamt` places, with zeros filling the low bits. Any `shamt` value above 16 behaves as 16.
- R3: Opcode encodings are LOAD=0, ADD=1, SUB=2, AND=3, OR=4 and XOR=5. When `use_prod`=1, `prod_in` is the operand. LOAD writes the operand, ADD writes acc+operand and SUB writes acc-operand. With `sat_mode`=0, a result that overflows wraps modulo 2^32.
- R4: A signed overflow on an accepted ADD or SUB sets `ov_flag` one cycle later. The flag stays set until `ov_clr` is 1 at a clock edge. If an overflow and `ov_clr` occur in the same cycle, the flag ends up set.
- R5: With `sat_mode`=1, a positive overflow writes 0x7FFFFFFF and a negative overflow writes 0x80000000. A result that does not overflow is written unchanged.
- R6: AND, OR and XOR with `use_prod`=0 use `data_in` zero-extended and unshifted, ignoring `shamt`. With `use_prod`=1 they use all 32 bits of `prod_in`. Boolean operations never set `ov_flag`.
- R7: Opcodes 6 and 7 leave the accumulator unchanged. When `in_valid`=0, nothing changes the accumulator.
- R8: With `st_hi`=1, `st_word` is bits 31..16 of the accumulator shifted left by the amount in `st_shift`. A value of 1 shifts by 1, a value of 4 shifts by 4, and every other value shifts by 0.
- R9: With `st_hi`=0, `st_word` is accumulator bits 15..0, whatever the value of `st_shift`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation offered this cycle |
| in_ready | output | 1 | Always 1; no back-pressure |
| op | input | 3 | Operation code |
| use_prod | input | 1 | 1 selects the product word as operand |
| shamt | input | 5 | Input scaler left-shift amount |
| data_in | input | 16 | 16-bit data operand |
| prod_in | input | 32 | 32-bit product operand |
| sat_mode | input | 1 | 1 = saturate, 0 = wrap |
| ov_clr | input | 1 | Clears the sticky overflow flag |
| st_hi | input | 1 | 1 = store high half, 0 = low half |
| st_shift | input | 3 | Store shift amount (1 or 4, else 0) |
| st_word | output | 16 | Word to be stored |
| acc_out | output | 32 | Accumulator value |
| ov_flag | output | 1 | Sticky overflow flag |

## Verification
The hardest case to reach from the ports is an overflow and an `ov_clr` landing on the same clock edge. The bench first loads 0x7FFFFFFF through the product port. It then issues an ADD of 1 with `ov_clr` held high in that same cycle, and checks that the flag is set afterwards. Saturation at both limits is reached the same way: the bench loads an extreme value through the product port, then applies a scaled data word that pushes the result past the limit.

// File: rtl/acc_dp_pkg.sv
package acc_dp_pkg;
  typedef enum logic [2:0] {
    OP_LOAD  = 3'd0,
    OP_ADD   = 3'd1,
    OP_SUB   = 3'd2,
    OP_AND   = 3'd3,
    OP_OR    = 3'd4,
    OP_XOR   = 3'd5,
    OP_HOLD6 = 3'd6,
    OP_HOLD7 = 3'd7
  } acc_op_e;
endpackage

// File: rtl/acc_in_scaler.sv
module acc_in_scaler #(
  parameter int DW = 16,
  parameter int AW = 32,
  parameter int SW = 5
) (
  input  logic [DW-1:0] data,
  input  logic [SW-1:0] shamt,
  output logic [AW-1:0] scaled
);
  localparam int MAXSH = AW - DW;
  logic [SW-1:0] eff;
  logic [AW-1:0] ext;

  always_comb begin
    ext = {{(AW-DW){data[DW-1]}}, data};
    eff = (int'(shamt) > MAXSH) ? SW'(MAXSH) : shamt;
    scaled = ext << eff;
  end
endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
  import acc_dp_pkg::*;
#(
  parameter int AW = 32
) (
  input  acc_op_e       op,
  input  logic [AW-1:0] a,
  input  logic [AW-1:0] b_arith,
  input  logic [AW-1:0] b_bool,
  input  logic          sat_mode,
  output logic [AW-1:0] res,
  output logic          ovf,
  output logic          wr
);
  localparam logic [AW-1:0] SAT_MAX = {1'b0, {(AW-1){1'b1}}};
  localparam logic [AW-1:0] SAT_MIN = {1'b1, {(AW-1){1'b0}}};
  logic [AW:0] wide;

  always_comb begin
    wide = '0;
    ovf  = 1'b0;
    wr   = 1'b1;
    res  = a;
    unique case (op)
      OP_LOAD: res = b_arith;
      OP_ADD, OP_SUB: begin
        if (op == OP_ADD) wide = {a[AW-1], a} + {b_arith[AW-1], b_arith};
        else              wide = {a[AW-1], a} - {b_arith[AW-1], b_arith};
        ovf = wide[AW] ^ wide[AW-1];
        if (ovf && sat_mode) res = wide[AW] ? SAT_MIN : SAT_MAX;
        else                 res = wide[AW-1:0];
      end
      OP_AND: res = a & b_bool;
      OP_OR:  res = a | b_bool;
      OP_XOR: res = a ^ b_bool;
      default: wr = 1'b0;
    endcase
  end
endmodule

// File: rtl/acc_store_shifter.sv
module acc_store_shifter #(
  parameter int AW = 32,
  parameter int DW = 16
) (
  input  logic [AW-1:0] acc,
  input  logic          hi,
  input  logic [2:0]    code,
  output logic [DW-1:0] word
);
  always_comb begin
    if (!hi) word = acc[DW-1:0];
    else begin
      unique case (code)
        3'd1:    word = acc[AW-2 -: DW];
        3'd4:    word = acc[AW-5 -: DW];
        default: word = acc[AW-1 -: DW];
      endcase
    end
  end
endmodule

// File: rtl/acc_datapath_core.sv
module acc_datapath_core
  import acc_dp_pkg::*;
#(
  parameter int DW = 16,
  parameter int SW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [2:0]    op,
  input  logic          use_prod,
  input  logic [SW-1:0] shamt,
  input  logic [DW-1:0] data_in,
  input  logic [2*DW-1:0] prod_in,
  input  logic          sat_mode,
  input  logic          ov_clr,
  input  logic          st_hi,
  input  logic [2:0]    st_shift,
  output logic [DW-1:0] st_word,
  output logic [2*DW-1:0] acc_out,
  output logic          ov_flag
);
  localparam int AW = 2 * DW;
  localparam logic [AW-1:0] SAT_MAX = {1'b0, {(AW-1){1'b1}}};
  localparam logic [AW-1:0] SAT_MIN = {1'b1, {(AW-1){1'b0}}};

  logic [AW-1:0] acc_q, scaled, b_arith, b_bool, alu_res;
  logic          ov_q, alu_ovf, alu_wr, fire, is_bool;
  acc_op_e       op_e;

  assign in_ready = 1'b1;
  assign fire     = in_valid && in_ready;
  assign op_e     = acc_op_e'(op);
  assign is_bool  = (op_e == OP_AND) || (op_e == OP_OR) || (op_e == OP_XOR);

  acc_in_scaler #(.DW(DW), .AW(AW), .SW(SW)) i_scaler (
    .data(data_in), .shamt(shamt), .scaled(scaled)
  );

  assign b_arith = use_prod ? prod_in : scaled;
  assign b_bool  = use_prod ? prod_in : {{(AW-DW){1'b0}}, data_in};

  acc_alu_core #(.AW(AW)) i_alu (
    .op(op_e), .a(acc_q), .b_arith(b_arith), .b_bool(b_bool),
    .sat_mode(sat_mode), .res(alu_res), .ovf(alu_ovf), .wr(alu_wr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      ov_q  <= 1'b0;
    end else begin
      if (fire && alu_wr) acc_q <= alu_res;
      ov_q <= (ov_q && !ov_clr) || (fire && alu_ovf);
    end
  end

  acc_store_shifter #(.AW(AW), .DW(DW)) i_store (
    .acc(acc_q), .hi(st_hi), .code(st_shift), .word(st_word)
  );

  assign acc_out = acc_q;
  assign ov_flag = ov_q;

  assert_always_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready);
  assert_sticky_ov_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_q && !ov_clr) |=> ov_q);
  assert_sat_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && sat_mode && alu_ovf) |=> (acc_q == SAT_MAX || acc_q == SAT_MIN));
  assert_bool_no_ov_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && is_bool && !ov_q) |=> !ov_q);
  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(acc_q));
endmodule

// File: tb/test_acc_datapath_core.sv
module test_acc_datapath_core;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        in_valid = 0, use_prod = 0, sat_mode = 0, ov_clr = 0, st_hi = 1;
  logic        in_ready, ov_flag;
  logic [2:0]  op = 0, st_shift = 0;
  logic [4:0]  shamt = 0;
  logic [15:0] data_in = 0, st_word;
  logic [31:0] prod_in = 0, acc_out;
  int errors = 0, checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_datapath_core i_acc_datapath_core (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op(op), .use_prod(use_prod), .shamt(shamt), .data_in(data_in),
    .prod_in(prod_in), .sat_mode(sat_mode), .ov_clr(ov_clr), .st_hi(st_hi),
    .st_shift(st_shift), .st_word(st_word), .acc_out(acc_out), .ov_flag(ov_flag)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic do_op(input logic [2:0] o, input logic up, input logic [4:0] sh,
                       input logic [15:0] d, input logic [31:0] p,
                       input logic sat, input logic clr, input logic v = 1'b1);
    @(negedge clk);
    in_valid = v; op = o; use_prod = up; shamt = sh; data_in = d;
    prod_in = p; sat_mode = sat; ov_clr = clr;
    @(negedge clk);
    in_valid = 0; ov_clr = 0;
  endtask

  task automatic t_reset;
    check("R1 acc after reset", acc_out, 32'h0);
    check("R1 ov after reset", {31'b0, ov_flag}, 32'h0);
    check("R1 ready", {31'b0, in_ready}, 32'h1);
  endtask

  task automatic t_scaler;
    do_op(0, 0, 0, 16'h8001, 0, 0, 0);  check("R2 shift0", acc_out, 32'hFFFF8001);
    do_op(0, 0, 16, 16'h8001, 0, 0, 0); check("R2 shift16", acc_out, 32'h80010000);
    do_op(0, 0, 4, 16'h8001, 0, 0, 0);  check("R2 shift4", acc_out, 32'hFFF80010);
    do_op(0, 0, 31, 16'h8001, 0, 0, 0); check("R2 shift31 clamps", acc_out, 32'h80010000);
  endtask

  task automatic t_arith;
    do_op(0, 0, 8, 16'h1234, 0, 0, 0);  check("R3 load", acc_out, 32'h00123400);
    do_op(1, 0, 0, 16'h0100, 0, 0, 0);  check("R3 add", acc_out, 32'h00123500);
    do_op(2, 0, 0, 16'hFFFF, 0, 0, 0);  check("R3 sub neg", acc_out, 32'h00123501);
    do_op(1, 1, 0, 0, 32'h10000000, 0, 0); check("R3 add prod", acc_out, 32'h10123501);
  endtask

  task automatic t_overflow;
    do_op(0, 1, 0, 0, 32'h7FFFFFFF, 0, 0);
    do_op(1, 0, 0, 16'h0001, 0, 0, 0);
    check("R3 wrap", acc_out, 32'h80000000);
    check("R4 ov set", {31'b0, ov_flag}, 1);
    do_op(1, 0, 0, 16'h0001, 0, 0, 0);
    check("R4 ov sticky", {31'b0, ov_flag}, 1);
    do_op(1, 0, 0, 16'h0001, 0, 0, 1, 1'b0);
    check("R4 ov cleared", {31'b0, ov_flag}, 0);
    check("R7 idle hold", acc_out, 32'h80000001);
    do_op(0, 1, 0, 0, 32'h7FFFFFFF, 0, 0);
    do_op(1, 0, 0, 16'h0001, 0, 0, 1);
    check("R4 set wins over clear", {31'b0, ov_flag}, 1);
  endtask

  task automatic t_saturate;
    do_op(0, 1, 0, 0, 32'h7FFFFFFF, 1, 1);
    do_op(1, 0, 16, 16'h7FFF, 0, 1, 0);
    check("R5 pos sat", acc_out, 32'h7FFFFFFF);
    do_op(0, 1, 0, 0, 32'h80000000, 1, 1);
    do_op(2, 0, 0, 16'h0001, 0, 1, 0);
    check("R5 neg sat", acc_out, 32'h80000000);
    check("R4 ov on sat", {31'b0, ov_flag}, 1);
    do_op(0, 0, 0, 16'h000A, 0, 1, 1);
    do_op(1, 0, 0, 16'h0005, 0, 1, 0);
    check("R5 no-ovf passes", acc_out, 32'h0000000F);
  endtask

  task automatic t_bool;
    do_op(0, 1, 0, 0, 32'hFFFFFFFF, 0, 1);
    do_op(3, 0, 4, 16'h80F0, 0, 0, 0); check("R6 and zero-ext", acc_out, 32'h000080F0);
    do_op(4, 1, 0, 0, 32'h0F000000, 0, 0); check("R6 or prod", acc_out, 32'h0F0080F0);
    do_op(5, 0, 9, 16'hFFFF, 0, 0, 0); check("R6 xor", acc_out, 32'h0F007F0F);
    do_op(5, 1, 0, 0, 32'hFFFFFFFF, 0, 0);
    check("R6 no ov", {31'b0, ov_flag}, 0);
  endtask

  task automatic t_hold;
    do_op(0, 1, 0, 0, 32'h12345678, 0, 0);
    do_op(6, 1, 0, 0, 32'hFFFFFFFF, 0, 0); check("R7 op6", acc_out, 32'h12345678);
    do_op(7, 1, 0, 0, 32'hFFFFFFFF, 0, 0); check("R7 op7", acc_out, 32'h12345678);
    do_op(1, 1, 0, 0, 32'h1, 0, 0, 1'b0);  check("R7 not valid", acc_out, 32'h12345678);
  endtask

  task automatic t_store;
    @(negedge clk);
    st_hi = 1; st_shift = 0; #1 check("R8 hi sh0", {16'b0, st_word}, 32'h1234);
    st_shift = 1; #1 check("R8 hi sh1", {16'b0, st_word}, 32'h2468);
    st_shift = 4; #1 check("R8 hi sh4", {16'b0, st_word}, 32'h2345);
    st_shift = 3; #1 check("R8 code3 as 0", {16'b0, st_word}, 32'h1234);
    st_shift = 7; #1 check("R8 code7 as 0", {16'b0, st_word}, 32'h1234);
    st_hi = 0; st_shift = 4; #1 check("R9 low", {16'b0, st_word}, 32'h5678);
    st_shift = 1; #1 check("R9 low sh1", {16'b0, st_word}, 32'h5678);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_scaler();
    t_arith();
    t_overflow();
    t_saturate();
    t_bool();
    t_hold();
    t_store();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule